// File: doc/BRIEF.md
# Signed-Digit On-line Multiplier

This block multiplies two numbers that arrive as streams of signed K-bit digits, most significant digit first, and returns product digits in the same order. Every digit is a plain two's-complement machine integer, so the radix is R = 2^K. The operands are fractions: digit j of an operand has weight R^-(j+1). The unit keeps two operand digit banks that fill by one position per step, a wide running residual, and a step counter. A step appends one new row (the whole Y bank times the new x digit) and one new column (the earlier X digits times the new y digit) to the product matrix. It then rounds off the leading digit of the residual, removes it, and shifts what remains up by one digit.

A caller starts with two initialise commands, which produce no digit. It then sends n-2 extend commands carrying the remaining operand digits, followed by complete commands that feed zero digits and drain the residual. The digit-by-word products are formed one digit position per clock, so a step at index t keeps the unit busy for t+2 cycles. Commands are only taken while the unit is idle. A step issued once all DIGS bank positions are used is refused with a one-cycle overflow pulse.

Top module: `olm_mul`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, res_valid and ovf_err are all low.
- R2: The unit takes a command only in a cycle where busy is low and cmd_valid is high. A step with index t, counted from the last restart, holds busy high for exactly t+2 cycles after the cycle in which it was taken.
- R3: cmd_op 0 is initialise. An initialise that does not directly follow another initialise restarts the unit: the counter, both digit banks and the residual are cleared, and this step gets index 0. An initialise that follows an initialise continues as the next step. No initialise step ever raises res_valid.
- R4: cmd_op 1 is extend and cmd_op 2 is complete. Each raises res_valid for exactly one cycle, the cycle in which busy falls. A complete ignores x_dig and y_dig and acts as an extend with two zero digits.
- R5: The digit emitted by step t (t >= 2) has weight R^-(t-1). For n-digit operands driven through 2n+2 steps (2n+2 <= DIGS), the sum of the emitted digits times their weights equals the exact product of the two operands.
- R6: If a sequence is stopped before the residual is drained, the emitted digits differ from the exact product by at most half a unit of the last emitted digit.
- R7: Every emitted digit lies in the range -R/2 to +R/2 (res_dig is K+1 bits wide, two's complement).
- R8: An extend, complete or continuing initialise that arrives when the counter equals DIGS is refused. ovf_err pulses for one cycle, busy stays low, no digit is produced, and a later restarting initialise works as normal.
- R9: Commands presented while busy is high have no effect on the results.
- R10: cmd_op 3 is reserved. It is ignored: no busy, no digit, no error, and no change to the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 initialise, 1 extend, 2 complete, 3 reserved |
| x_dig | input | K | Signed digit of operand X |
| y_dig | input | K | Signed digit of operand Y |
| busy | output | 1 | Step in progress; commands are not taken |
| res_valid | output | 1 | One-cycle strobe for res_dig |
| res_dig | output | K+1 | Signed product digit |
| ovf_err | output | 1 | One-cycle pulse on a refused step |

## Verification
The bench rebuilds each product from the emitted digits and compares it with an exact integer product. It uses operands of all-maximum and all-minimum digits with mixed signs, and a short two-digit case. A wrong column alignment or a wrong rounding constant shows up as a product that is off by a multiple of a digit weight. The bench drives a step once the banks are full: a unit without the guard would emit a digit or go busy instead of pulsing the error. It drives junk commands while busy and a reserved opcode mid-sequence, and a unit that takes either corrupts the rebuilt product. The bench also counts busy cycles per step, which catches a unit that forms the wrong number of digit products or loses the continuing second initialise.

// File: rtl/olm_pkg.sv
package olm_pkg;

    typedef enum logic [1:0] {
        OP_INIT     = 2'd0,
        OP_EXTEND   = 2'd1,
        OP_COMPLETE = 2'd2,
        OP_RSVD     = 2'd3
    } olm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_EMIT  = 2'd2
    } olm_state_e;

    // control captured when a step is taken
    typedef struct packed {
        logic emit;      // step produces a visible digit
        logic was_init;  // step came from an initialise command
    } olm_step_ctl_t;

    function automatic logic op_is_step(input olm_op_e op);
        return op != OP_RSVD;
    endfunction

    function automatic logic op_zeroes_digits(input olm_op_e op);
        return op == OP_COMPLETE;
    endfunction

endpackage

// File: rtl/olm_operand_bank.sv
module olm_operand_bank #(
    parameter int K    = 8,
    parameter int DIGS = 8,
    parameter int IW   = 4
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                wr_y,
    input  logic                wr_x,
    input  logic [IW-1:0]       wr_idx,
    input  logic signed [K-1:0] y_in,
    input  logic signed [K-1:0] x_in,
    input  logic [IW-1:0]       rd_idx,
    output logic signed [K-1:0] x_rd,
    output logic signed [K-1:0] y_rd
);
    localparam int AW = (DIGS > 1) ? $clog2(DIGS) : 1;

    logic [DIGS-1:0][K-1:0] x_vec;
    logic [DIGS-1:0][K-1:0] y_vec;
    logic [AW-1:0]          rd_sel;

    for (genvar g = 0; g < DIGS; g++) begin : g_cell
        logic [K-1:0] x_cell;
        logic [K-1:0] y_cell;
        logic         hit;

        assign hit = (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                x_cell <= '0;
                y_cell <= '0;
            end else begin
                // a new y digit may land in the same cycle as a clear
                if (wr_y && hit)
                    y_cell <= y_in;
                else if (clr)
                    y_cell <= '0;
                if (clr)
                    x_cell <= '0;
                else if (wr_x && hit)
                    x_cell <= x_in;
            end
        end

        assign x_vec[g] = x_cell;
        assign y_vec[g] = y_cell;
    end

    assign rd_sel = rd_idx[AW-1:0];

    always_comb begin
        if (rd_idx < IW'(DIGS)) begin
            x_rd = $signed(x_vec[rd_sel]);
            y_rd = $signed(y_vec[rd_sel]);
        end else begin
            x_rd = '0;
            y_rd = '0;
        end
    end

endmodule

// File: rtl/olm_term_gen.sv
module olm_term_gen #(
    parameter int K    = 8,
    parameter int DIGS = 8,
    parameter int IW   = 4,
    parameter int PW   = 90
)(
    input  logic signed [K-1:0]  x_new,
    input  logic signed [K-1:0]  y_new,
    input  logic signed [K-1:0]  x_old_m,
    input  logic signed [K-1:0]  y_m,
    input  logic [IW-1:0]        pos,
    output logic signed [PW-1:0] term
);
    localparam int EW  = 2 * K + 2;
    localparam int SHW = $clog2(K * DIGS + 1);

    logic signed [EW-1:0] xn_e, yn_e, xo_e, ym_e;
    logic signed [EW-1:0] psum;
    logic signed [PW-1:0] pext;
    logic [SHW-1:0]       shamt;

    always_comb begin
        xn_e = {{(K+2){x_new[K-1]}},   x_new};
        yn_e = {{(K+2){y_new[K-1]}},   y_new};
        xo_e = {{(K+2){x_old_m[K-1]}}, x_old_m};
        ym_e = {{(K+2){y_m[K-1]}},     y_m};
        // row element plus column element at bank position pos
        psum = (xn_e * ym_e) + (yn_e * xo_e);
        pext = {{(PW-EW){psum[EW-1]}}, psum};
        if (pos < IW'(DIGS))
            shamt = SHW'(K * (DIGS - 1 - int'(pos)));
        else
            shamt = '0;
        term = pext <<< shamt;
    end

endmodule

// File: rtl/olm_digit_pick.sv
module olm_digit_pick #(
    parameter int K    = 8,
    parameter int DIGS = 8,
    parameter int PW   = 90
)(
    input  logic signed [PW-1:0] res_in,
    output logic signed [K:0]    digit,
    output logic signed [PW-1:0] next_res
);
    localparam int              FB   = K * (DIGS + 2);
    localparam int              MW   = PW - FB;
    localparam logic [PW-1:0]   HALF = PW'(1) << (FB - 1);

    logic                 neg;
    logic [PW-1:0]        mag;
    logic [PW-1:0]        rnd;
    logic [MW-1:0]        dmag;
    logic signed [MW-1:0] dsg;
    logic signed [PW-1:0] dext;
    logic signed [PW-1:0] rem;

    always_comb begin
        neg  = res_in[PW-1];
        mag  = neg ? $unsigned(-res_in) : $unsigned(res_in);
        rnd  = mag + HALF;                  // round half away from zero
        dmag = rnd[PW-1:FB];
        dsg  = neg ? -$signed(dmag) : $signed(dmag);
        digit = $signed(dsg[K:0]);
        dext = {{(PW-MW){dsg[MW-1]}}, dsg};
        rem  = res_in - (dext <<< FB);
        next_res = rem <<< K;               // walk one digit upward
    end

endmodule

// File: rtl/olm_mul.sv
module olm_mul
    import olm_pkg::*;
#(
    parameter int K    = 8,
    parameter int DIGS = 8
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic signed [K-1:0] x_dig,
    input  logic signed [K-1:0] y_dig,
    output logic                busy,
    output logic                res_valid,
    output logic signed [K:0]   res_dig,
    output logic                ovf_err
);
    localparam int IW = $clog2(DIGS + 1);
    localparam int PW = K * (DIGS + 3) + 2;

    olm_state_e           state;
    olm_step_ctl_t        ctl;
    logic [IW-1:0]        step;
    logic [IW-1:0]        pos;
    logic signed [K-1:0]  x_hold, y_hold;
    logic signed [PW-1:0] resid;

    olm_op_e              op_in;
    logic                 take, restart, full, start, reject;
    logic [IW-1:0]        base_step;
    logic signed [K-1:0]  x_eff, y_eff;

    logic [IW-1:0]        bank_wr_idx;
    logic signed [K-1:0]  bank_x_rd, bank_y_rd;
    logic signed [PW-1:0] term;
    logic signed [K:0]    pick_digit;
    logic signed [PW-1:0] pick_next;

    always_comb begin
        op_in     = olm_op_e'(cmd_op);
        take      = (state == ST_IDLE) && cmd_valid && op_is_step(op_in);
        restart   = (op_in == OP_INIT) && !ctl.was_init;
        base_step = restart ? '0 : step;
        full      = (base_step >= IW'(DIGS));
        start     = take && !full;
        reject    = take && full;
        x_eff     = op_zeroes_digits(op_in) ? '0 : x_dig;
        y_eff     = op_zeroes_digits(op_in) ? '0 : y_dig;
        bank_wr_idx = (state == ST_EMIT) ? step : base_step;
    end

    olm_operand_bank #(.K(K), .DIGS(DIGS), .IW(IW)) i_bank (
        .clk    (clk),
        .rst    (rst),
        .clr    (start && restart),
        .wr_y   (start),
        .wr_x   (state == ST_EMIT),
        .wr_idx (bank_wr_idx),
        .y_in   (y_eff),
        .x_in   (x_hold),
        .rd_idx (pos),
        .x_rd   (bank_x_rd),
        .y_rd   (bank_y_rd)
    );

    olm_term_gen #(.K(K), .DIGS(DIGS), .IW(IW), .PW(PW)) i_term (
        .x_new   (x_hold),
        .y_new   (y_hold),
        .x_old_m (bank_x_rd),
        .y_m     (bank_y_rd),
        .pos     (pos),
        .term    (term)
    );

    olm_digit_pick #(.K(K), .DIGS(DIGS), .PW(PW)) i_pick (
        .res_in   (resid),
        .digit    (pick_digit),
        .next_res (pick_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctl       <= '0;
            step      <= '0;
            pos       <= '0;
            x_hold    <= '0;
            y_hold    <= '0;
            resid     <= '0;
            res_valid <= 1'b0;
            res_dig   <= '0;
            ovf_err   <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            ovf_err   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (reject) begin
                        ovf_err <= 1'b1;
                    end else if (start) begin
                        state        <= ST_ACCUM;
                        pos          <= '0;
                        step         <= base_step;
                        x_hold       <= x_eff;
                        y_hold       <= y_eff;
                        ctl.emit     <= (op_in != OP_INIT);
                        ctl.was_init <= (op_in == OP_INIT);
                        if (restart)
                            resid <= '0;
                    end
                end
                ST_ACCUM: begin
                    resid <= resid + term;
                    if (pos == step)
                        state <= ST_EMIT;
                    else
                        pos <= pos + 1'b1;
                end
                ST_EMIT: begin
                    resid     <= pick_next;
                    step      <= step + 1'b1;
                    res_valid <= ctl.emit;
                    res_dig   <= pick_digit;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/olm_mul_chk.sv
module olm_mul_chk #(
    parameter int K = 8
)(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             res_valid,
    input logic signed [K:0] res_dig,
    input logic             ovf_err
);
    localparam logic signed [K:0] DMAX = (K+1)'(2 ** (K - 1));
    localparam logic signed [K:0] DMIN = -DMAX;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !res_valid && !ovf_err)); // R1

    AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(busy)); // R2

    AST_VALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R4

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_dig <= DMAX && res_dig >= DMIN)); // R7

    AST_NO_OVERFLOW_WORK: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> (!busy && !res_valid)); // R8

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> !ovf_err); // R8

endmodule

bind olm_mul olm_mul_chk #(.K(K)) i_olm_mul_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .res_valid (res_valid),
    .res_dig   (res_dig),
    .ovf_err   (ovf_err)
);

// File: tb/test_olm_mul.sv
module test_olm_mul;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic signed [7:0] x_dig = '0;
    logic signed [7:0] y_dig = '0;
    logic              busy, res_valid, ovf_err;
    logic signed [8:0] res_dig;

    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q[$];
    longint acc = 0;
    int    xa[8];
    int    ya[8];

    always #4 clk = ~clk;   // 125 MHz

    olm_mul i_olm_mul (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .x_dig(x_dig), .y_dig(y_dig), .busy(busy), .res_valid(res_valid),
        .res_dig(res_dig), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: pop the expected weight, accumulate the digit
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 R4 unexpected digit", longint'(res_dig), 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                acc += longint'(res_dig) * (longint'(1) << (8 * e));
                chk(res_dig <= 128 && res_dig >= -128, "R7 digit range", longint'(res_dig), 128);
            end
        end
    end

    // one step: wait idle, present, count busy cycles (R2)
    task automatic step_cmd(input int op, input int xd, input int yd, input int t,
                            input int e, input bit poke);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        x_dig     = 8'(xd);
        y_dig     = 8'(yd);
        if (e >= 0) exp_q.push_back(e);
        @(negedge clk);
        if (poke) begin
            cmd_op = 2'd1;      // junk while busy, R9
            x_dig  = 8'sd55;
            y_dig  = -8'sd77;
        end else begin
            cmd_valid = 1'b0;
        end
        begin
            int cnt;
            cnt = 0;
            while (busy) begin
                cnt++;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
            chk(cnt == t + 2, "R2 busy length", cnt, t + 2);
        end
    endtask

    task automatic ovf_cmd(input int op);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        x_dig     = 8'sd9;
        y_dig     = 8'sd9;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(ovf_err == 1'b1, "R8 error pulse", ovf_err, 1);
        chk(busy == 1'b0, "R8 no busy", busy, 0);
        @(negedge clk);
        chk(ovf_err == 1'b0 && res_valid == 1'b0, "R8 quiet after", ovf_err, 0);
    endtask

    task automatic rsv_cmd();
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy && !res_valid && !ovf_err, "R10 reserved ignored", busy, 0);
        @(negedge clk);
        chk(!busy && !res_valid && !ovf_err, "R10 reserved quiet", res_valid, 0);
    endtask

    task automatic run_seq(input int n, input int steps, input longint tol,
                           input int poke_at, input int rsv_at, input string req);
        longint xv, yv, diff;
        acc = 0;
        for (int t = 0; t < steps; t++) begin
            int op, xd, yd, e;
            op = (t < 2) ? 0 : ((t < n) ? 1 : 2);
            xd = (t < n) ? xa[t] : ((t * 37) % 200) - 100;  // R4 junk on complete
            yd = (t < n) ? ya[t] : ((t * 53) % 200) - 100;
            e  = (t >= 2) ? (2 * n + 1 - t) : -1;
            if (t == rsv_at) rsv_cmd();
            step_cmd(op, xd, yd, t, e, t == poke_at);
        end
        @(negedge clk);
        @(negedge clk);
        xv = 0;
        yv = 0;
        for (int j = 0; j < n; j++) begin
            xv = xv * 256 + xa[j];
            yv = yv * 256 + ya[j];
        end
        diff = xv * yv - acc;
        if (diff < 0) diff = -diff;
        chk(diff <= tol, req, acc, xv * yv);
        chk(exp_q.size() == 0, "R4 one digit per step", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !res_valid && !ovf_err, "R1 reset quiet", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !res_valid && !ovf_err, "R1 after reset", res_valid, 0);

        // R5 all-maximum digits
        xa = '{127, 127, 127, 0, 0, 0, 0, 0};
        ya = '{127, 127, 127, 0, 0, 0, 0, 0};
        run_seq(3, 8, 0, -1, -1, "R5 max digits");

        // R8 banks full
        ovf_cmd(1);
        ovf_cmd(2);

        // R3 restart after a full sequence, most negative digits
        xa = '{-128, -128, -128, 0, 0, 0, 0, 0};
        ya = '{127, -1, -128, 0, 0, 0, 0, 0};
        run_seq(3, 8, 0, -1, -1, "R3 R5 restart negative");

        // R5 two-digit operands
        xa = '{-5, 100, 0, 0, 0, 0, 0, 0};
        ya = '{77, -128, 0, 0, 0, 0, 0, 0};
        run_seq(2, 6, 0, -1, -1, "R5 two digits");

        // R6 truncated four-digit product
        xa = '{90, -100, 33, -7, 0, 0, 0, 0};
        ya = '{-64, 99, -100, 100, 0, 0, 0, 0};
        run_seq(4, 8, 32768, -1, -1, "R6 truncated");

        // R9 junk while busy, R10 reserved mid-sequence
        xa = '{-1, 64, -77, 0, 0, 0, 0, 0};
        ya = '{3, -128, 127, 0, 0, 0, 0, 0};
        run_seq(3, 8, 0, 3, 4, "R9 R10 product intact");

        // R5 zero operand
        xa = '{0, 0, 0, 0, 0, 0, 0, 0};
        ya = '{-128, 127, -128, 0, 0, 0, 0, 0};
        run_seq(3, 8, 0, -1, -1, "R5 zero operand");

        summary();
    end

endmodule